// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Array

This block is a fully associative array of page translations. Every slot holds a virtual page tag, a physical page number, an address-space number, a global flag, a read-enable mask and a write-enable mask with one bit per privilege mode, a fault-on-read bit, a fault-on-write bit, and a valid bit. A lookup port compares a virtual page number and the current address-space number against all slots in the same cycle. It returns the physical page, the permission fields, a hit flag and the index of the matching slot.

Maintenance goes through a three-bit command input, with at most one command per cycle. One command inserts a translation at a rotating replacement pointer. Another only advances that pointer. The other three flush state at three scopes: the whole array, every non-global slot, or the slots matching one page and address space. The slot under the pointer is always presented on a separate indexed view, so a page-table refill engine can inspect the victim before it overwrites it.

Top module: `astlb_top`

## Requirements
- R1: A lookup hits on a slot only when that slot is valid, its tag equals `lk_vpn`, and either its global flag is set or its address-space number equals `lk_asn`.
- R2: When several slots hit, `lk_idx` and the returned fields come from the lowest-indexed hitting slot. On a miss, `lk_hit`, `lk_idx`, `lk_ppn`, the masks and the fault bits are all zero.
- R3: Command 1 (insert) loads `cmd_vpn`, `cmd_asn` and the `ins_*` fields into the slot named by `ptr` and marks that slot valid, replacing any translation it held. The pointer then advances by one.
- R4: The pointer steps from DEPTH-1 back to 0, so the (DEPTH+1)-th insert after the pointer was at zero overwrites slot 0.
- R5: Command 3 (flush all) invalidates every slot and returns `ptr` to 0.
- R6: Command 4 (flush non-global) invalidates every slot whose global flag is clear. Global slots keep their contents and stay valid.
- R7: Command 5 (flush address) invalidates every valid slot whose tag equals `cmd_vpn` and which is global or holds `cmd_asn`. All other slots are left untouched.
- R8: `ix_*` always show the slot under `ptr`. Command 2 (advance) moves `ptr` by one and changes no slot.
- R9: Lookup outputs reflect the state before any update made at the same clock edge. A command issued in a cycle is first visible to lookups in the following cycle.
- R10: After reset every slot is invalid and `ptr` is 0. Command codes 0, 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_asn | input | ASN_W | Current address-space number |
| lk_hit | output | 1 | Lookup found a matching slot |
| lk_idx | output | IW | Index of the lowest matching slot |
| lk_ppn | output | PPN_W | Physical page of the matching slot |
| lk_rd_en | output | MODE_N | Per-mode read enables of the matching slot |
| lk_wr_en | output | MODE_N | Per-mode write enables of the matching slot |
| lk_frd | output | 1 | Fault-on-read bit of the matching slot |
| lk_fwr | output | 1 | Fault-on-write bit of the matching slot |
| cmd_op | input | 3 | 0 idle, 1 insert, 2 advance, 3 flush all, 4 flush non-global, 5 flush address |
| cmd_vpn | input | VPN_W | Page for insert and flush-address |
| cmd_asn | input | ASN_W | Address space for insert and flush-address |
| ins_ppn | input | PPN_W | Physical page to insert |
| ins_glob | input | 1 | Global flag to insert |
| ins_rd_en | input | MODE_N | Read enables to insert |
| ins_wr_en | input | MODE_N | Write enables to insert |
| ins_frd | input | 1 | Fault-on-read bit to insert |
| ins_fwr | input | 1 | Fault-on-write bit to insert |
| ptr | output | IW | Replacement pointer |
| ix_valid | output | 1 | Valid bit of the slot under the pointer |
| ix_vpn | output | VPN_W | Tag of the slot under the pointer |
| ix_ppn | output | PPN_W | Physical page of the slot under the pointer |
| ix_asn | output | ASN_W | Address-space number of the slot under the pointer |
| ix_glob | output | 1 | Global flag of the slot under the pointer |

## Verification
The hardest state to reach from the ports is an array holding several live copies of one page. In that state some copies are global and some are tied to other address spaces, and they sit at indices that the rotating pointer has already wrapped past. Only there do lowest-index selection, the global exemption during flushes and the wrap overwrite interact. The stimulus draws pages from a set of eight and address spaces from a set of four, so duplicates are frequent. It favours inserts so the pointer wraps many times, and a directed pass fills all DEPTH slots before overwriting slot 0.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
   typedef enum logic [2:0] {
      CMD_IDLE     = 3'd0,
      CMD_INSERT   = 3'd1,
      CMD_ADVANCE  = 3'd2,
      CMD_FLUSH_ALL = 3'd3,
      CMD_FLUSH_NG = 3'd4,
      CMD_FLUSH_VA = 3'd5
   } tlb_cmd_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/tlbx_match.sv
module tlbx_match #(
   parameter int DEPTH = 48,
   parameter int VPN_W = 20,
   parameter int ASN_W = 8
) (
   input  logic [DEPTH-1:0] valid,
   input  logic [DEPTH-1:0] glob,
   input  logic [VPN_W-1:0] tags [DEPTH],
   input  logic [ASN_W-1:0] asns [DEPTH],
   input  logic [VPN_W-1:0] key_vpn,
   input  logic [ASN_W-1:0] key_asn,
   output logic [DEPTH-1:0] hit
);
   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign hit[g] = valid[g] && (tags[g] == key_vpn) &&
                      (glob[g] || (asns[g] == key_asn));
   end
endmodule

// File: rtl/tlbx_prio.sv
module tlbx_prio #(
   parameter int N  = 48,
   parameter int IW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
      any = |req;
   end

   // R2: the chosen index is a requester and no lower one requests
   a_r2_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> (req[idx] && ((req & ~({N{1'b1}} << idx)) == '0)));
   a_r2_idle_idx: assert property (@(posedge clk) disable iff (!rst_n)
      !any |-> (idx == '0));
endmodule

// File: rtl/tlbx_ptr.sv
module tlbx_ptr #(
   parameter int DEPTH = 48,
   parameter int PW    = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic          clear,
   output logic [PW-1:0] ptr
);
   logic [PW-1:0] nxt;

   if ((1 << PW) == DEPTH) begin : g_pow2
      assign nxt = ptr + 1'b1;
   end else begin : g_cmp
      assign nxt = (ptr == PW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ptr <= '0;
      else if (clear) ptr <= '0;
      else if (step)  ptr <= nxt;
   end

   a_r4_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= PW'(DEPTH - 1));
   a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clear && ptr == PW'(DEPTH - 1)) |=> (ptr == '0));
endmodule

// File: rtl/astlb_top.sv
module astlb_top
   import tlbx_pkg::*;
#(
   parameter int DEPTH  = 48,
   parameter int VPN_W  = 20,
   parameter int PPN_W  = 20,
   parameter int ASN_W  = 8,
   parameter int MODE_N = 4,
   parameter int IW     = idx_width(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASN_W-1:0]  lk_asn,
   output logic              lk_hit,
   output logic [IW-1:0]     lk_idx,
   output logic [PPN_W-1:0]  lk_ppn,
   output logic [MODE_N-1:0] lk_rd_en,
   output logic [MODE_N-1:0] lk_wr_en,
   output logic              lk_frd,
   output logic              lk_fwr,
   input  logic [2:0]        cmd_op,
   input  logic [VPN_W-1:0]  cmd_vpn,
   input  logic [ASN_W-1:0]  cmd_asn,
   input  logic [PPN_W-1:0]  ins_ppn,
   input  logic              ins_glob,
   input  logic [MODE_N-1:0] ins_rd_en,
   input  logic [MODE_N-1:0] ins_wr_en,
   input  logic              ins_frd,
   input  logic              ins_fwr,
   output logic [IW-1:0]     ptr,
   output logic              ix_valid,
   output logic [VPN_W-1:0]  ix_vpn,
   output logic [PPN_W-1:0]  ix_ppn,
   output logic [ASN_W-1:0]  ix_asn,
   output logic              ix_glob
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("astlb_top: DEPTH must be at least 2");
   end
   if (IW < $clog2(DEPTH)) begin : g_bad_iw
      $error("astlb_top: IW too narrow for DEPTH");
   end
   if (VPN_W < 1 || PPN_W < 1 || ASN_W < 1 || MODE_N < 1) begin : g_bad_w
      $error("astlb_top: field widths must be positive");
   end

   logic [DEPTH-1:0]  e_valid, e_glob, e_frd, e_fwr;
   logic [VPN_W-1:0]  e_tag [DEPTH];
   logic [PPN_W-1:0]  e_ppn [DEPTH];
   logic [ASN_W-1:0]  e_asn [DEPTH];
   logic [MODE_N-1:0] e_rd  [DEPTH];
   logic [MODE_N-1:0] e_wr  [DEPTH];

   tlb_cmd_e cmd;
   logic do_ins, do_adv, do_all, do_ng, do_va;
   logic [DEPTH-1:0] lk_vec, va_vec;

   assign cmd    = tlb_cmd_e'(cmd_op);
   assign do_ins = (cmd == CMD_INSERT);
   assign do_adv = (cmd == CMD_ADVANCE);
   assign do_all = (cmd == CMD_FLUSH_ALL);
   assign do_ng  = (cmd == CMD_FLUSH_NG);
   assign do_va  = (cmd == CMD_FLUSH_VA);

   tlbx_ptr #(.DEPTH(DEPTH), .PW(IW)) u_ptr (
      .clk(clk), .rst_n(rst_n), .step(do_ins | do_adv), .clear(do_all), .ptr(ptr)
   );

   tlbx_match #(.DEPTH(DEPTH), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_lk_match (
      .valid(e_valid), .glob(e_glob), .tags(e_tag), .asns(e_asn),
      .key_vpn(lk_vpn), .key_asn(lk_asn), .hit(lk_vec)
   );

   tlbx_match #(.DEPTH(DEPTH), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_va_match (
      .valid(e_valid), .glob(e_glob), .tags(e_tag), .asns(e_asn),
      .key_vpn(cmd_vpn), .key_asn(cmd_asn), .hit(va_vec)
   );

   tlbx_prio #(.N(DEPTH), .IW(IW)) u_prio (
      .clk(clk), .rst_n(rst_n), .req(lk_vec), .any(lk_hit), .idx(lk_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            e_valid[i] <= 1'b0; e_glob[i] <= 1'b0;
            e_frd[i]   <= 1'b0; e_fwr[i]  <= 1'b0;
            e_tag[i]   <= '0;   e_ppn[i]  <= '0;   e_asn[i] <= '0;
            e_rd[i]    <= '0;   e_wr[i]   <= '0;
         end
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (do_all) begin
               e_valid[i] <= 1'b0; e_glob[i] <= 1'b0;
               e_frd[i]   <= 1'b0; e_fwr[i]  <= 1'b0;
               e_tag[i]   <= '0;   e_ppn[i]  <= '0;   e_asn[i] <= '0;
               e_rd[i]    <= '0;   e_wr[i]   <= '0;
            end else if (do_ins && ptr == IW'(i)) begin
               e_valid[i] <= 1'b1;      e_glob[i] <= ins_glob;
               e_frd[i]   <= ins_frd;   e_fwr[i]  <= ins_fwr;
               e_tag[i]   <= cmd_vpn;   e_ppn[i]  <= ins_ppn;
               e_asn[i]   <= cmd_asn;
               e_rd[i]    <= ins_rd_en; e_wr[i]   <= ins_wr_en;
            end else if (do_ng && !e_glob[i]) begin
               e_valid[i] <= 1'b0;
            end else if (do_va && va_vec[i]) begin
               e_valid[i] <= 1'b0;
            end
         end
      end
   end

   assign lk_ppn   = lk_hit ? e_ppn[lk_idx] : '0;
   assign lk_rd_en = lk_hit ? e_rd[lk_idx]  : '0;
   assign lk_wr_en = lk_hit ? e_wr[lk_idx]  : '0;
   assign lk_frd   = lk_hit & e_frd[lk_idx];
   assign lk_fwr   = lk_hit & e_fwr[lk_idx];

   assign ix_valid = e_valid[ptr];
   assign ix_vpn   = e_tag[ptr];
   assign ix_ppn   = e_ppn[ptr];
   assign ix_asn   = e_asn[ptr];
   assign ix_glob  = e_glob[ptr];

   // R3: inserted slot is valid and carries the requested tag
   a_r3_insert_lands: assert property (@(posedge clk) disable iff (!rst_n)
      do_ins |=> (e_valid[$past(ptr)] && e_tag[$past(ptr)] == $past(cmd_vpn)));
   // R5: flush-all empties the array and rewinds the pointer
   a_r5_flush_all: assert property (@(posedge clk) disable iff (!rst_n)
      do_all |=> (e_valid == '0 && ptr == '0));
   // R6: global slots survive, non-global ones are gone
   a_r6_global_keep: assert property (@(posedge clk) disable iff (!rst_n)
      do_ng |=> (((e_valid & $past(e_valid & e_glob)) == $past(e_valid & e_glob)) &&
                 ((e_valid & ~e_glob) == '0)));
   // R7: no slot selected by the address flush stays valid
   a_r7_flush_va: assert property (@(posedge clk) disable iff (!rst_n)
      do_va |=> ((e_valid & $past(va_vec)) == '0));
   // R8: advance leaves the valid set unchanged
   a_r8_adv_stable: assert property (@(posedge clk) disable iff (!rst_n)
      do_adv |=> $stable(e_valid));
endmodule

// File: tb/astlb_top_tb.sv
module astlb_top_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH  = 48;
   localparam int VPN_W  = 20;
   localparam int PPN_W  = 20;
   localparam int ASN_W  = 8;
   localparam int MODE_N = 4;
   localparam int IW     = $clog2(DEPTH);

   logic clk = 1'b0, rst_n = 1'b0;
   logic [VPN_W-1:0] lk_vpn = '0, cmd_vpn = '0, ix_vpn;
   logic [ASN_W-1:0] lk_asn = '0, cmd_asn = '0, ix_asn;
   logic lk_hit, lk_frd, lk_fwr, ix_valid, ix_glob;
   logic [IW-1:0] lk_idx, ptr;
   logic [PPN_W-1:0] lk_ppn, ins_ppn = '0, ix_ppn;
   logic [MODE_N-1:0] lk_rd_en, lk_wr_en, ins_rd_en = '0, ins_wr_en = '0;
   logic [2:0] cmd_op = 3'd0;
   logic ins_glob = 1'b0, ins_frd = 1'b0, ins_fwr = 1'b0;

   astlb_top #(.DEPTH(DEPTH), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASN_W(ASN_W),
               .MODE_N(MODE_N)) u_dut (
      .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_asn(lk_asn),
      .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_ppn(lk_ppn), .lk_rd_en(lk_rd_en),
      .lk_wr_en(lk_wr_en), .lk_frd(lk_frd), .lk_fwr(lk_fwr), .cmd_op(cmd_op),
      .cmd_vpn(cmd_vpn), .cmd_asn(cmd_asn), .ins_ppn(ins_ppn), .ins_glob(ins_glob),
      .ins_rd_en(ins_rd_en), .ins_wr_en(ins_wr_en), .ins_frd(ins_frd),
      .ins_fwr(ins_fwr), .ptr(ptr), .ix_valid(ix_valid), .ix_vpn(ix_vpn),
      .ix_ppn(ix_ppn), .ix_asn(ix_asn), .ix_glob(ix_glob)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   // reference model
   bit               m_v [DEPTH];
   bit               m_g [DEPTH];
   bit               m_fr[DEPTH];
   bit               m_fw[DEPTH];
   logic [VPN_W-1:0] m_tag[DEPTH];
   logic [PPN_W-1:0] m_ppn[DEPTH];
   logic [ASN_W-1:0] m_asn[DEPTH];
   logic [MODE_N-1:0] m_rd[DEPTH];
   logic [MODE_N-1:0] m_wr[DEPTH];
   int m_ptr = 0;
   int n_chk = 0, n_bad = 0;
   bit done = 0;

   function automatic bit m_match(int i, logic [VPN_W-1:0] v, logic [ASN_W-1:0] a);
      return m_v[i] && m_tag[i] == v && (m_g[i] || m_asn[i] == a);
   endfunction

   function automatic int m_find(logic [VPN_W-1:0] v, logic [ASN_W-1:0] a);
      for (int i = 0; i < DEPTH; i++) if (m_match(i, v, a)) return i;
      return -1;
   endfunction

   task automatic m_apply(int op);
      case (op)
         1: begin
            m_v[m_ptr] = 1; m_g[m_ptr] = ins_glob; m_fr[m_ptr] = ins_frd;
            m_fw[m_ptr] = ins_fwr; m_tag[m_ptr] = cmd_vpn; m_ppn[m_ptr] = ins_ppn;
            m_asn[m_ptr] = cmd_asn; m_rd[m_ptr] = ins_rd_en; m_wr[m_ptr] = ins_wr_en;
            m_ptr = (m_ptr + 1) % DEPTH;
         end
         2: m_ptr = (m_ptr + 1) % DEPTH;
         3: begin
            for (int i = 0; i < DEPTH; i++) begin
               m_v[i] = 0; m_g[i] = 0; m_fr[i] = 0; m_fw[i] = 0;
               m_tag[i] = '0; m_ppn[i] = '0; m_asn[i] = '0; m_rd[i] = '0; m_wr[i] = '0;
            end
            m_ptr = 0;
         end
         4: for (int i = 0; i < DEPTH; i++) if (!m_g[i]) m_v[i] = 0;
         5: begin
            bit kill [DEPTH];
            for (int i = 0; i < DEPTH; i++) kill[i] = m_match(i, cmd_vpn, cmd_asn);
            for (int i = 0; i < DEPTH; i++) if (kill[i]) m_v[i] = 0;
         end
         default: ;
      endcase
   endtask

   task automatic drive_cmd(int op, logic [VPN_W-1:0] v, logic [ASN_W-1:0] a,
                            logic [PPN_W-1:0] p, bit g);
      cmd_op = 3'(op); cmd_vpn = v; cmd_asn = a; ins_ppn = p; ins_glob = g;
      ins_rd_en = MODE_N'(p); ins_wr_en = MODE_N'(p >> 4);
      ins_frd = p[8]; ins_fwr = p[9];
   endtask

   task automatic run_cmd(int op, logic [VPN_W-1:0] v, logic [ASN_W-1:0] a,
                          logic [PPN_W-1:0] p, bit g);
      @(negedge clk);
      drive_cmd(op, v, a, p, g);
      @(posedge clk);
      m_apply(op);
   endtask

   task automatic look_now(string req);
      int e = m_find(lk_vpn, lk_asn);
      bit eh = (e >= 0);
      logic [IW-1:0] ei = eh ? IW'(e) : '0;
      logic [PPN_W-1:0] ep = eh ? m_ppn[e] : '0;
      logic [MODE_N-1:0] er = eh ? m_rd[e] : '0;
      logic [MODE_N-1:0] ew = eh ? m_wr[e] : '0;
      bit efr = eh ? m_fr[e] : 0;
      bit efw = eh ? m_fw[e] : 0;
      n_chk++;
      if (lk_hit !== eh || lk_idx !== ei || lk_ppn !== ep || lk_rd_en !== er ||
          lk_wr_en !== ew || lk_frd !== efr || lk_fwr !== efw) begin
         n_bad++;
         $display("FAIL %s lookup vpn=%h asn=%h: got hit=%b idx=%0d ppn=%h rd=%h wr=%h fr=%b fw=%b, expected hit=%b idx=%0d ppn=%h rd=%h wr=%h fr=%b fw=%b",
                  req, lk_vpn, lk_asn, lk_hit, lk_idx, lk_ppn, lk_rd_en, lk_wr_en,
                  lk_frd, lk_fwr, eh, ei, ep, er, ew, efr, efw);
      end
   endtask

   task automatic chk_look(string req, logic [VPN_W-1:0] v, logic [ASN_W-1:0] a);
      @(negedge clk);
      cmd_op = 3'd0; lk_vpn = v; lk_asn = a;
      #1;
      look_now(req);
   endtask

   task automatic chk_index(string req);
      @(negedge clk);
      cmd_op = 3'd0;
      #1;
      n_chk++;
      if (ptr !== IW'(m_ptr) || ix_valid !== m_v[m_ptr] || ix_vpn !== m_tag[m_ptr] ||
          ix_ppn !== m_ppn[m_ptr] || ix_asn !== m_asn[m_ptr] || ix_glob !== m_g[m_ptr]) begin
         n_bad++;
         $display("FAIL %s index view: got ptr=%0d v=%b vpn=%h ppn=%h asn=%h g=%b, expected ptr=%0d v=%b vpn=%h ppn=%h asn=%h g=%b",
                  req, ptr, ix_valid, ix_vpn, ix_ppn, ix_asn, ix_glob, m_ptr, m_v[m_ptr],
                  m_tag[m_ptr], m_ppn[m_ptr], m_asn[m_ptr], m_g[m_ptr]);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, got timeout, expected finish");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < DEPTH; i++) begin
         m_v[i] = 0; m_g[i] = 0; m_fr[i] = 0; m_fw[i] = 0; m_tag[i] = '0;
         m_ppn[i] = '0; m_asn[i] = '0; m_rd[i] = '0; m_wr[i] = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R10: reset state
      chk_index("R10");
      chk_look("R10", 20'h5, 8'h1);

      // R1: address-space match versus mismatch
      run_cmd(1, 20'h5, 8'h1, 20'h0A3F1, 0);
      chk_look("R1", 20'h5, 8'h1);
      chk_look("R1", 20'h5, 8'h2);
      chk_look("R1", 20'h6, 8'h1);
      // R1/R2: global copy at slot 1; asn 1 still picks slot 0
      run_cmd(1, 20'h5, 8'h7, 20'h0B2C4, 1);
      chk_look("R1", 20'h5, 8'h2);
      chk_look("R2", 20'h5, 8'h1);
      // R10: unused codes change nothing
      run_cmd(6, 20'h5, 8'h1, 20'h0, 0);
      run_cmd(7, 20'h5, 8'h1, 20'h0, 0);
      run_cmd(0, 20'h5, 8'h1, 20'h0, 0);
      chk_look("R10", 20'h5, 8'h1);
      chk_index("R10");
      // R6: only the global copy survives
      run_cmd(4, 20'h0, 8'h0, 20'h0, 0);
      chk_look("R6", 20'h5, 8'h1);
      // R7: global slot is hit by any address space in the flush
      run_cmd(5, 20'h5, 8'h3, 20'h0, 0);
      chk_look("R7", 20'h5, 8'h3);
      run_cmd(1, 20'h9, 8'h2, 20'h01111, 0);
      run_cmd(1, 20'h9, 8'h3, 20'h02222, 0);
      run_cmd(5, 20'h9, 8'h2, 20'h0, 0);
      chk_look("R7", 20'h9, 8'h2);
      chk_look("R7", 20'h9, 8'h3);
      // R8: advance moves pointer, entries untouched
      chk_index("R8");
      run_cmd(2, 20'h0, 8'h0, 20'h0, 0);
      chk_index("R8");
      chk_look("R8", 20'h9, 8'h3);
      // R5: flush all
      run_cmd(3, 20'h0, 8'h0, 20'h0, 0);
      chk_index("R5");
      chk_look("R5", 20'h9, 8'h3);
      // R3/R4: fill every slot then wrap onto slot 0
      for (int i = 0; i < DEPTH; i++) run_cmd(1, 20'h100 + VPN_W'(i), 8'h4, 20'h30000 + PPN_W'(i), 0);
      chk_index("R4");
      run_cmd(1, 20'h999, 8'h4, 20'h0ABCD, 0);
      chk_look("R4", 20'h100, 8'h4);
      chk_look("R3", 20'h999, 8'h4);
      chk_look("R3", 20'h101, 8'h4);
      // R9: same-cycle lookup sees old state
      @(negedge clk);
      drive_cmd(1, 20'h777, 8'h4, 20'h04444, 0);
      lk_vpn = 20'h777; lk_asn = 8'h4;
      #1;
      look_now("R9");
      @(posedge clk);
      m_apply(1);
      chk_look("R9", 20'h777, 8'h4);
      @(negedge clk);
      drive_cmd(3, 20'h0, 8'h0, 20'h0, 0);
      lk_vpn = 20'h777; lk_asn = 8'h4;
      #1;
      look_now("R9");
      @(posedge clk);
      m_apply(3);

      // random mix
      for (int n = 0; n < 2500; n++) begin
         int r = int'($urandom_range(0, 99));
         int op = (r < 50) ? 1 : (r < 60) ? 2 : (r < 66) ? 4 : (r < 82) ? 5 :
                  (r < 84) ? 3 : 0;
         run_cmd(op, VPN_W'($urandom_range(0, 7)), ASN_W'($urandom_range(0, 3)),
                 PPN_W'($urandom), bit'($urandom_range(0, 3) == 0));
         chk_look("R1", VPN_W'($urandom_range(0, 7)), ASN_W'($urandom_range(0, 3)));
         if (n % 8 == 0) chk_index("R8");
      end

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule